// File: doc/BRIEF.md
# Shared Interrupt Request Controller

This block lets several functions on one card share a single active-low interrupt request line towards the host. Each function has a small control register and a small status register, both reached through one register write/read port. Each function also has an event input. The block merges the events of the functions that are switched on and routed into one request output.

Each function picks one of two signalling schemes. In the legacy scheme the pending flag follows the function's event input, and the function clears that input once it has been serviced. In the acknowledge scheme an event latches the pending flag. The flag stays set until the host writes zero to it. Each such acknowledge releases the request line for one clock, so an edge-triggered host sees a fresh falling edge if any routed event is still pending.

All pins are plain control and status signals. The register port has no handshake: a write takes effect on the clock edge where `reg_wr` is high, and read data is a combinational view of the addressed register. No port of this block carries a data stream.

Top module: `shirq_top`

## Requirements
- R1: Out of reset `irq_n` is 1 and every register of every function reads 0.
- R2: Address bit 0 picks the register (0 = control, 1 = status) and the upper address bits pick the function. In the control register, bit 0 enables the function and bit 2 routes its interrupt to the shared line. Other control bits read 0.
- R3: In the status register, bit 0 selects the scheme (0 = legacy, 1 = acknowledge) and bit 1 is the pending flag. Writing 1 to bit 1 never sets the flag, and bits 7..2 read 0.
- R4: In legacy scheme a function's pending flag equals the value its event input had at the previous clock edge.
- R5: In acknowledge scheme an event sets the pending flag. The flag holds after the event drops, until a status write with bit 1 = 0. An event in the same cycle as that write keeps the flag set.
- R6: `irq_n` goes low one clock after any function with enable = 1, route = 1 and pending = 1 exists. It is high when no such function exists.
- R7: A status write with bit 1 = 0 to a function that is in acknowledge scheme forces `irq_n` high for the following cycle, whatever is pending.
- R8: After that released cycle `irq_n` returns low if any enabled, routed function is still pending, which gives a new falling edge.
- R9: A function whose enable or route bit is 0 never pulls `irq_n` low, although its pending flag still sets.
- R10: Status bit 1 of a legacy-scheme function reads the card-wide request: the OR of pending over enabled, routed functions. An acknowledge-scheme function reads its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | {function index, register select} |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| evt_i | input | NFUNC | Per-function event inputs |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bench aims at these corner cases:
- An acknowledge that arrives while a legacy function still holds its event. A design that skips the release cycle would leave the line low with no new edge, and the host would miss the second event.
- An event that coincides with its own acknowledge. A design that lets the clear win would lose that event.
- Functions that are disabled or not routed. A design that ignores the gating would raise a request nobody asked for.
- The mirrored flag in legacy functions. Showing the function's own flag instead of the card-wide value would hide pending work from a legacy driver.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int DW           = 8;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_ROUTE_BIT = 2;
  localparam int ST_MODE_BIT  = 0;
  localparam int ST_PEND_BIT  = 1;

  typedef enum logic { MODE_LEGACY = 1'b0, MODE_ACK = 1'b1 } irq_mode_e;
endpackage

// File: rtl/shirq_func.sv
module shirq_func
  import shirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_st,
  input  logic d_en,
  input  logic d_route,
  input  logic d_mode,
  input  logic d_pend,
  input  logic evt,
  output logic en,
  output logic route,
  output irq_mode_e mode,
  output logic pend,
  output logic ack
);
  // acknowledge strobe: host clears the flag of an acknowledge-scheme function
  assign ack = wr_st && (mode == MODE_ACK) && !d_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      route <= 1'b0;
      mode  <= MODE_LEGACY;
      pend  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en    <= d_en;
        route <= d_route;
      end
      if (wr_st) mode <= irq_mode_e'(d_mode);
      if (mode == MODE_LEGACY) pend <= evt;
      else                     pend <= (pend && !ack) || evt;
    end
  end

  AST_LEGACY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEGACY) |=> (pend == $past(evt))); // R4
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_ACK) && pend && !ack) |=> pend); // R5
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pend); // R5
endmodule

// File: rtl/shirq_merge.sv
module shirq_merge #(
  parameter int NFUNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFUNC-1:0] active,
  input  logic             ack_any,
  output logic             irq_n
);
  logic req;
  assign req = |active;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n <= 1'b1;
    else if (ack_any) irq_n <= 1'b1;
    else irq_n <= !req;
  end

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_any |=> irq_n); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(req)); // R6
endmodule

// File: rtl/shirq_top.sv
module shirq_top
  import shirq_pkg::*;
#(
  parameter int NFUNC = 2,
  localparam int FW = (NFUNC > 1) ? $clog2(NFUNC) : 1,
  localparam int AW = FW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NFUNC-1:0] evt_i,
  output logic             irq_n
);
  logic [FW-1:0]    sel;
  logic             is_st;
  logic [NFUNC-1:0] en, route, pend, ack, active;
  irq_mode_e        mode [NFUNC];
  logic             shared;
  logic             sel_legacy_st;
  logic             unused_wdata;

  assign sel    = reg_addr[AW-1:1];
  assign is_st  = reg_addr[0];
  assign active = en & route & pend;
  assign shared = |active;
  assign unused_wdata = ^reg_wdata[DW-1:3];

  for (genvar f = 0; f < NFUNC; f++) begin : g_func
    logic hit;
    assign hit = reg_wr && (sel == FW'(f));
    shirq_func u_func (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (hit && !is_st),
      .wr_st  (hit && is_st),
      .d_en   (reg_wdata[CTL_EN_BIT]),
      .d_route(reg_wdata[CTL_ROUTE_BIT]),
      .d_mode (reg_wdata[ST_MODE_BIT]),
      .d_pend (reg_wdata[ST_PEND_BIT]),
      .evt    (evt_i[f]),
      .en     (en[f]),
      .route  (route[f]),
      .mode   (mode[f]),
      .pend   (pend[f]),
      .ack    (ack[f])
    );
  end

  shirq_merge #(.NFUNC(NFUNC)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .ack_any(|ack),
    .irq_n  (irq_n)
  );

  always_comb begin
    reg_rdata     = '0;
    sel_legacy_st = 1'b0;
    for (int f = 0; f < NFUNC; f++) begin
      if (sel == FW'(f)) begin
        if (is_st) begin
          reg_rdata[ST_MODE_BIT] = mode[f];
          reg_rdata[ST_PEND_BIT] = (mode[f] == MODE_ACK) ? pend[f] : shared;
          sel_legacy_st          = (mode[f] == MODE_LEGACY);
        end else begin
          reg_rdata[CTL_EN_BIT]    = en[f];
          reg_rdata[CTL_ROUTE_BIT] = route[f];
        end
      end
    end
  end

  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_legacy_st |-> (reg_rdata[ST_PEND_BIT] == (|(en & route & pend)))); // R10
  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & route & pend) == '0) |=> irq_n); // R9
endmodule

// File: tb/tb_shirq_top.sv
module tb_shirq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] evt_i = '0;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  bit m_en[2], m_rt[2], m_pr[2], m_pd[2];
  bit m_irqn = 1'b1;

  always #2.5 clk = ~clk;

  shirq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_n(irq_n)
  );

  function automatic bit m_shared();
    return (m_en[0] && m_rt[0] && m_pd[0]) || (m_en[1] && m_rt[1] && m_pd[1]);
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    int fn = a[1];
    logic [7:0] v = '0;
    if (!a[0]) begin
      v[0] = m_en[fn];
      v[2] = m_rt[fn];
    end else begin
      v[0] = m_pr[fn];
      v[1] = m_pr[fn] ? m_pd[fn] : m_shared();
    end
    return v;
  endfunction

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit wr, logic [1:0] a, logic [7:0] d, logic [1:0] e);
    bit ack;
    bit any;
    int fn;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = e;
    #1;
    check("rdata", reg_rdata, m_read(a));
    @(posedge clk);
    fn  = a[1];
    ack = wr && a[0] && m_pr[fn] && !d[1];
    any = m_shared();
    for (int f = 0; f < 2; f++) begin
      if (!m_pr[f]) m_pd[f] = e[f];
      else          m_pd[f] = (m_pd[f] && !(ack && fn == f)) || e[f];
    end
    if (wr && !a[0]) begin m_en[fn] = d[0]; m_rt[fn] = d[2]; end
    if (wr && a[0])  m_pr[fn] = d[0];
    m_irqn = ack ? 1'b1 : !any;
    #1;
    check("irq_n", {7'b0, irq_n}, {7'b0, m_irqn});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check("irq_n in reset", {7'b0, irq_n}, 8'h01); // R1
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    for (int a = 0; a < 4; a++) cyc(0, 2'(a), 8'h00, 2'b00);

    tag = "R2";
    cyc(1, 2'd0, 8'hFF, 2'b00);
    cyc(0, 2'd0, 8'h00, 2'b00);
    cyc(1, 2'd0, 8'h05, 2'b00);

    tag = "R4";
    repeat (3) cyc(0, 2'd1, 8'h00, 2'b01);
    tag = "R6";
    repeat (2) cyc(0, 2'd1, 8'h00, 2'b00);

    tag = "R10";
    repeat (2) cyc(0, 2'd3, 8'h00, 2'b01);
    cyc(0, 2'd3, 8'h00, 2'b00);

    tag = "R3";
    cyc(1, 2'd3, 8'h03, 2'b00);
    cyc(0, 2'd3, 8'h00, 2'b00);
    cyc(1, 2'd3, 8'h03, 2'b00);
    cyc(0, 2'd3, 8'h00, 2'b00);
    cyc(1, 2'd2, 8'h05, 2'b00);

    tag = "R5";
    cyc(0, 2'd3, 8'h00, 2'b10);
    repeat (3) cyc(0, 2'd3, 8'h00, 2'b00);
    tag = "R7";
    cyc(1, 2'd3, 8'h01, 2'b00);
    repeat (2) cyc(0, 2'd3, 8'h00, 2'b00);

    tag = "R8";
    cyc(0, 2'd3, 8'h00, 2'b11);
    repeat (2) cyc(0, 2'd1, 8'h00, 2'b01);
    cyc(1, 2'd3, 8'h01, 2'b01);
    repeat (2) cyc(0, 2'd3, 8'h00, 2'b01);
    repeat (2) cyc(0, 2'd0, 8'h00, 2'b00);

    tag = "R5";
    cyc(0, 2'd3, 8'h00, 2'b10);
    cyc(1, 2'd3, 8'h01, 2'b10);
    cyc(0, 2'd3, 8'h00, 2'b00);
    cyc(1, 2'd3, 8'h01, 2'b00);
    cyc(0, 2'd3, 8'h00, 2'b00);

    tag = "R9";
    cyc(1, 2'd2, 8'h01, 2'b00);
    cyc(0, 2'd3, 8'h00, 2'b10);
    repeat (2) cyc(0, 2'd3, 8'h00, 2'b00);
    cyc(1, 2'd0, 8'h04, 2'b00);
    repeat (3) cyc(0, 2'd1, 8'h00, 2'b01);
    cyc(0, 2'd1, 8'h00, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule